// File: doc/BRIEF.md
# Configuration Header Command and Status Dwords

This block implements the first two dwords of the configuration header of a host-controller function. The first dword is a fixed identifier: a vendor code and a device code, both set by parameters. The second dword pairs a command word with a status word. The command word holds a few writable enables. One write-accepted bit controls nothing. The rest are constant bits. The status word holds two abort flags next to constant capability bits. Hardware sets the abort flags, and software clears them by writing ones.

Configuration accesses are dword-aligned. A write carries four byte enables, and each byte lane is handled on its own. Read data is combinational from the address. The enables in the command word leave the block as plain level outputs that steer the rest of the function. The function's bus-master logic sends single-cycle pulses when one of its cycles ends in a target abort or a master abort.

Top module: `cfgHdrCmdSts`

## Requirements
- R1: A read at byte address 0x00 returns the device code in bits 31:16 and the vendor code in bits 15:0. Writes to this address change nothing.
- R2: After reset, the dword at byte address 0x04 reads 0x0280_0000, and all four enable outputs are low.
- R3: Command bits 0, 1 and 2 are read-write and drive ioSpaceEn, memSpaceEn and busMasterEn respectively.
- R4: Command bit 4 is read-write and drives mwiEn.
- R5: Command bit 8 is read-write and reads back what was written. It drives no output.
- R6: Command bits 15:9, 7:5 and 3 always read 0, whatever is written.
- R7: Status bits 11:0 and 15:14 always read the STATUS_FIXED parameter value (default 0x0280), whatever is written. They appear in dword bits 27:16 and 31:30.
- R8: A one-cycle pulse on tgtAbortEvt sets status bit 12 (dword bit 28). A pulse on mstAbortEvt sets status bit 13 (dword bit 29). Each flag stays set until it is cleared.
- R9: Writing 1 to dword bit 28 or 29 with byte enable 3 set clears that flag. Writing 0 to the bit, or writing without byte enable 3, leaves the flag as it was.
- R10: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R11: Each byte enable gates only its own byte. Byte enables 0 and 1 cover command bits 7:0 and 15:8. Byte enables 2 and 3 cover the status bytes. A write to the status half therefore leaves the command half unchanged, and a write to the command half leaves the status half unchanged.
- R12: An access at any other byte address reads 0 and writes nothing. This includes addresses whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | ADDR_W | Configuration byte address |
| cfgWrite | input | 1 | Write strobe, one cycle per write |
| cfgByteEn | input | 4 | Byte enables for the write |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data for cfgAddr (combinational) |
| tgtAbortEvt | input | 1 | Pulse: a mastered cycle received a target abort |
| mstAbortEvt | input | 1 | Pulse: a mastered cycle ended in a master abort |
| ioSpaceEn | output | 1 | I/O space enable (legacy emulation ports) |
| memSpaceEn | output | 1 | Memory space enable |
| busMasterEn | output | 1 | Bus-master enable |
| mwiEn | output | 1 | Memory-write-and-invalidate enable |

## Verification
The bench builds the block with ADDR_W = 8 and with distinctive identifier codes, 0x1A2B for the vendor and 0x3C4D for the device. With these codes, a swapped or mis-laned identifier field shows up as a wrong value. STATUS_FIXED keeps its default of 0x0280, so the reset value 0x0280_0000 is checked exactly. An 8-bit address reaches both mapped dwords, an unmapped dword at 0x08 and a misaligned address at 0x05. This lets the decode be checked for both hits and misses.

// File: rtl/cfgHdrPkg.sv
package cfgHdrPkg;

  // Writable command bits: 0,1,2 enables, 4 MWI, 8 no-function
  localparam logic [15:0] CMD_WR_MASK = 16'h0117;
  // Status bits set by hardware and cleared by writing one
  localparam logic [15:0] STS_W1C_MASK = 16'h3000;

  localparam int CMD_IO   = 0;
  localparam int CMD_MEM  = 1;
  localparam int CMD_BM   = 2;
  localparam int CMD_MWI  = 4;
  localparam int STS_TGT  = 12;
  localparam int STS_MST  = 13;

  // Strobes from control to datapath
  typedef struct packed {
    logic        selId;
    logic        selCmd;
    logic [15:0] cmdLaneMask;
    logic [15:0] stsClrMask;
  } hdrStrobe_t;

endpackage

// File: rtl/cfgHdrCtrl.sv
module cfgHdrCtrl
  import cfgHdrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrite,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWdata,
  output hdrStrobe_t        strobe
);

  localparam int DW_W = ADDR_W - 2;
  localparam logic [DW_W-1:0] ID_DW  = DW_W'(0);
  localparam logic [DW_W-1:0] CMD_DW = DW_W'(1);

  logic [DW_W-1:0] dwIdx;
  logic            aligned;
  logic [31:0]     laneBits;
  logic            wrCmd;

  assign dwIdx   = cfgAddr[ADDR_W-1:2];
  assign aligned = (cfgAddr[1:0] == 2'b00);

  // Expand each byte enable over its own byte
  for (genvar lane = 0; lane < 4; lane++) begin : gLane
    assign laneBits[lane*8 +: 8] = {8{cfgByteEn[lane]}};
  end

  assign wrCmd = cfgWrite && strobe.selCmd;

  always_comb begin
    strobe.selId       = aligned && (dwIdx == ID_DW);
    strobe.selCmd      = aligned && (dwIdx == CMD_DW);
    strobe.cmdLaneMask = wrCmd ? (laneBits[15:0] & CMD_WR_MASK) : 16'h0000;
    strobe.stsClrMask  = wrCmd ? (laneBits[31:16] & cfgWdata[31:16] & STS_W1C_MASK)
                               : 16'h0000;
  end

  // clk and rstN are not needed by the decode, which is purely combinational
  logic unusedCtl;
  assign unusedCtl = clk ^ rstN;

endmodule

// File: rtl/cfgHdrDatapath.sv
module cfgHdrDatapath
  import cfgHdrPkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h0000,
  parameter logic [15:0] DEVICE_ID    = 16'h0000,
  parameter logic [15:0] STATUS_FIXED = 16'h0280
) (
  input  logic        clk,
  input  logic        rstN,
  input  hdrStrobe_t  strobe,
  input  logic [31:0] cfgWdata,
  input  logic        tgtAbortEvt,
  input  logic        mstAbortEvt,
  output logic [31:0] cfgRdata,
  output logic [15:0] cmdWord
);

  localparam logic [15:0] STS_CONST = STATUS_FIXED & ~STS_W1C_MASK;

  logic [15:0] cmdReg;
  logic [15:0] stsFlags;
  logic [15:0] stsSet;
  logic [15:0] stsWord;

  // Command register: lane-masked merge, only writable bits can change
  always_ff @(posedge clk) begin
    if (!rstN) cmdReg <= 16'h0000;
    else       cmdReg <= (cmdReg & ~strobe.cmdLaneMask) |
                         (cfgWdata[15:0] & strobe.cmdLaneMask);
  end

  always_comb begin
    stsSet          = 16'h0000;
    stsSet[STS_TGT] = tgtAbortEvt;
    stsSet[STS_MST] = mstAbortEvt;
  end

  // Clear first, then set: a same-cycle event wins
  always_ff @(posedge clk) begin
    if (!rstN) stsFlags <= 16'h0000;
    else       stsFlags <= ((stsFlags & ~strobe.stsClrMask) | stsSet) & STS_W1C_MASK;
  end

  assign stsWord = STS_CONST | stsFlags;
  assign cmdWord = cmdReg;

  always_comb begin
    if (strobe.selId)       cfgRdata = {DEVICE_ID, VENDOR_ID};
    else if (strobe.selCmd) cfgRdata = {stsWord, cmdReg};
    else                    cfgRdata = 32'h0000_0000;
  end

endmodule

// File: rtl/cfgHdrCmdSts.sv
module cfgHdrCmdSts
  import cfgHdrPkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [15:0] VENDOR_ID    = 16'h0000,
  parameter logic [15:0] DEVICE_ID    = 16'h0000,
  parameter logic [15:0] STATUS_FIXED = 16'h0280
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrite,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              tgtAbortEvt,
  input  logic              mstAbortEvt,
  output logic              ioSpaceEn,
  output logic              memSpaceEn,
  output logic              busMasterEn,
  output logic              mwiEn
);

  hdrStrobe_t  strobe;
  logic [15:0] cmdWord;

  cfgHdrCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgAddr  (cfgAddr),
    .cfgWrite (cfgWrite),
    .cfgByteEn(cfgByteEn),
    .cfgWdata (cfgWdata),
    .strobe   (strobe)
  );

  cfgHdrDatapath #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .STATUS_FIXED(STATUS_FIXED)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWdata   (cfgWdata),
    .tgtAbortEvt(tgtAbortEvt),
    .mstAbortEvt(mstAbortEvt),
    .cfgRdata   (cfgRdata),
    .cmdWord    (cmdWord)
  );

  assign ioSpaceEn   = cmdWord[CMD_IO];
  assign memSpaceEn  = cmdWord[CMD_MEM];
  assign busMasterEn = cmdWord[CMD_BM];
  assign mwiEn       = cmdWord[CMD_MWI];

endmodule

// File: rtl/cfgHdrCmdSts_chk.sv
module cfgHdrCmdSts_chk #(
  parameter int          ADDR_W       = 8,
  parameter logic [15:0] VENDOR_ID    = 16'h0000,
  parameter logic [15:0] DEVICE_ID    = 16'h0000,
  parameter logic [15:0] STATUS_FIXED = 16'h0280
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic              cfgWrite,
  input logic [3:0]        cfgByteEn,
  input logic [31:0]       cfgWdata,
  input logic [31:0]       cfgRdata,
  input logic              tgtAbortEvt,
  input logic              mstAbortEvt,
  input logic              ioSpaceEn,
  input logic              memSpaceEn,
  input logic              busMasterEn,
  input logic              mwiEn
);

  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(4);

  logic atCmd;
  logic atId;
  logic atMapped;
  assign atCmd    = (cfgAddr == A_CMD);
  assign atId     = (cfgAddr == A_ID);
  assign atMapped = atCmd || atId;

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    atId |-> cfgRdata == {DEVICE_ID, VENDOR_ID}); // R1

  AST_ENABLES_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    atCmd |-> (cfgRdata[2:0] == {busMasterEn, memSpaceEn, ioSpaceEn}) && (cfgRdata[4] == mwiEn)); // R3

  AST_CMD_CONST_BITS: assert property (@(posedge clk) disable iff (!rstN)
    atCmd |-> (cfgRdata[15:9] == 7'd0) && (cfgRdata[7:5] == 3'd0) && !cfgRdata[3]); // R6

  AST_STS_CONST_BITS: assert property (@(posedge clk) disable iff (!rstN)
    atCmd |-> (cfgRdata[27:16] == STATUS_FIXED[11:0]) && (cfgRdata[31:30] == STATUS_FIXED[15:14])); // R7

  AST_TGT_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    tgtAbortEvt |=> (!atCmd || cfgRdata[28])); // R10

  AST_MST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    mstAbortEvt |=> (!atCmd || cfgRdata[29])); // R8

  AST_TGT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && atCmd && cfgByteEn[3] && cfgWdata[28] && !tgtAbortEvt)
      |=> (!atCmd || !cfgRdata[28])); // R9

  AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !cfgByteEn[0])
      |=> $stable({ioSpaceEn, memSpaceEn, busMasterEn, mwiEn})); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !atMapped |-> cfgRdata == 32'h0); // R12

endmodule

bind cfgHdrCmdSts cfgHdrCmdSts_chk #(
  .ADDR_W      (ADDR_W),
  .VENDOR_ID   (VENDOR_ID),
  .DEVICE_ID   (DEVICE_ID),
  .STATUS_FIXED(STATUS_FIXED)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgAddr    (cfgAddr),
  .cfgWrite   (cfgWrite),
  .cfgByteEn  (cfgByteEn),
  .cfgWdata   (cfgWdata),
  .cfgRdata   (cfgRdata),
  .tgtAbortEvt(tgtAbortEvt),
  .mstAbortEvt(mstAbortEvt),
  .ioSpaceEn  (ioSpaceEn),
  .memSpaceEn (memSpaceEn),
  .busMasterEn(busMasterEn),
  .mwiEn      (mwiEn)
);

// File: tb/cfgHdrCmdSts_tb.sv
module cfgHdrCmdSts_tb;

  localparam int          ADDR_W = 8;
  localparam logic [15:0] VEN    = 16'h1A2B;
  localparam logic [15:0] DEV    = 16'h3C4D;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] cfgAddr;
  logic              cfgWrite;
  logic [3:0]        cfgByteEn;
  logic [31:0]       cfgWdata;
  logic [31:0]       cfgRdata;
  logic              tgtAbortEvt;
  logic              mstAbortEvt;
  logic              ioSpaceEn, memSpaceEn, busMasterEn, mwiEn;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cfgHdrCmdSts #(
    .ADDR_W(ADDR_W), .VENDOR_ID(VEN), .DEVICE_ID(DEV)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrite(cfgWrite),
    .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .tgtAbortEvt(tgtAbortEvt), .mstAbortEvt(mstAbortEvt),
    .ioSpaceEn(ioSpaceEn), .memSpaceEn(memSpaceEn),
    .busMasterEn(busMasterEn), .mwiEn(mwiEn)
  );

  // {addr, byteEn, wdata, expected readback at same addr}
  localparam int NVEC = 9;
  localparam logic [75:0] VEC [NVEC] = '{
    {8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0280_0117},  // R3 R4 R5 R6 R7
    {8'h04, 4'h1, 32'h0000_0000, 32'h0280_0100},  // R11 low byte only
    {8'h04, 4'h2, 32'h0000_0000, 32'h0280_0000},  // R5 bit 8 cleared
    {8'h04, 4'hC, 32'h0000_01FF, 32'h0280_0000},  // R11 status half write
    {8'h04, 4'h1, 32'h0000_0005, 32'h0280_0005},  // R3
    {8'h00, 4'hF, 32'hFFFF_FFFF, {16'h3C4D, 16'h1A2B}}, // R1
    {8'h08, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 unmapped
    {8'h05, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 misaligned
    {8'h04, 4'h1, 32'h0000_00F2, 32'h0280_0012}   // R4 R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                         input logic tEv, input logic mEv);
    @(negedge clk);
    cfgAddr = a; cfgByteEn = be; cfgWdata = d; cfgWrite = 1'b1;
    tgtAbortEvt = tEv; mstAbortEvt = mEv;
    @(posedge clk); #1;
    cfgWrite = 1'b0; tgtAbortEvt = 1'b0; mstAbortEvt = 1'b0;
  endtask

  task automatic pulse(input logic tEv, input logic mEv);
    @(negedge clk);
    tgtAbortEvt = tEv; mstAbortEvt = mEv;
    @(posedge clk); #1;
    tgtAbortEvt = 1'b0; mstAbortEvt = 1'b0;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  initial begin : watchdog
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    rstN = 1'b0; cfgAddr = '0; cfgWrite = 1'b0; cfgByteEn = '0; cfgWdata = '0;
    tgtAbortEvt = 1'b0; mstAbortEvt = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2 reset state
    readAt(8'h04, rd);
    check("R2 reset dword", rd, 32'h0280_0000);
    check("R2 reset outputs", {28'h0, ioSpaceEn, memSpaceEn, busMasterEn, mwiEn}, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC[i][75:68], VEC[i][67:64], VEC[i][63:32], 1'b0, 1'b0);
      readAt(VEC[i][75:68], rd);
      check($sformatf("vector %0d (R1/R3-R7/R11/R12)", i), rd, VEC[i][31:0]);
    end

    // R3 R4 outputs after last vector: cmd = 0x0012
    check("R3 R4 enable outputs", {28'h0, ioSpaceEn, memSpaceEn, busMasterEn, mwiEn},
          {28'h0, 1'b0, 1'b1, 1'b0, 1'b1});

    // R12 unmapped writes left command intact
    readAt(8'h04, rd);
    check("R12 command intact", rd, 32'h0280_0012);

    // R8 target abort sets bit 28, sticky
    pulse(1'b1, 1'b0);
    repeat (3) @(posedge clk);
    readAt(8'h04, rd);
    check("R8 target abort sticky", rd, 32'h1280_0012);

    // R9 writing 0, or 1 without byte enable 3, keeps flag
    doWrite(8'h04, 4'h8, 32'h0000_0000, 1'b0, 1'b0);
    readAt(8'h04, rd);
    check("R9 write zero keeps flag", rd, 32'h1280_0012);
    doWrite(8'h04, 4'h7, 32'h1000_0000, 1'b0, 1'b0);
    readAt(8'h04, rd);
    check("R9 no lane3 keeps flag", rd, 32'h1280_0000);

    // R8 master abort sets bit 29
    pulse(1'b0, 1'b1);
    readAt(8'h04, rd);
    check("R8 master abort", rd, 32'h3280_0000);

    // R9 clear only target flag
    doWrite(8'h04, 4'h8, 32'h1000_0000, 1'b0, 1'b0);
    readAt(8'h04, rd);
    check("R9 clear target flag", rd, 32'h2280_0000);

    // R10 set and clear in the same cycle: set wins
    doWrite(8'h04, 4'h8, 32'h3000_0000, 1'b1, 1'b0);
    readAt(8'h04, rd);
    check("R10 set beats clear", rd, 32'h1280_0000);

    // R11 status clear leaves command; R9 full clear
    doWrite(8'h04, 4'h1, 32'h0000_0007, 1'b0, 1'b0);
    doWrite(8'h04, 4'hC, 32'hFFFF_FFF0, 1'b0, 1'b0);
    readAt(8'h04, rd);
    check("R11 R9 clear keeps command", rd, 32'h0280_0007);

    // R1 ID write ignored
    doWrite(8'h00, 4'hF, 32'h0000_0000, 1'b0, 1'b0);
    readAt(8'h00, rd);
    check("R1 ID after write", rd, {DEV, VEN});

    // R2 reset again restores defaults
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    readAt(8'h04, rd);
    check("R2 reset restores", rd, 32'h0280_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule